// File: doc/BRIEF.md
# Synchronous DRAM Mode Register and Burst Sequencer

This block sits on the command side of a synchronous DRAM-style memory. At every rising clock edge on which clock enable is high, it decodes the chip select and the three strobes. It keeps a small mode register, loaded from the address bus. That register sets the read latency, the number of beats per burst and the order in which columns are visited.

For each read or write command, the block walks the column sequence of the burst, one column per enabled clock. It presents each column together with a data-valid strobe. The strobe is delayed by the programmed latency, so a downstream array or data path can move one word per strobe. A busy flag stays high while any beat of a burst is still to come.

A burst ends in one of three ways: its length runs out, a burst-stop command arrives, or a new read or write command replaces it. A full-page burst runs until one of the last two happens. Holding clock enable low freezes the whole block, including its outputs.

Top module: `sdram_burst_seq`

## Requirements
- R1: A command takes effect only at a rising edge with cs_ni=0 and cke_i=1. The encodings of {ras_ni,cas_ni,we_ni} are: 000 mode load, 101 read, 100 write, 110 burst stop. Any other combination, and any edge with cs_ni=1, changes nothing. Reads and writes produce identical column sequences.
- R2: A mode load stores addr_i[6:0]. Bits [2:0] hold the length code, bit 3 the order (0 linear, 1 interleaved) and bits [6:4] the latency code. After reset the mode is latency code 1, length code 0, linear.
- R3: With effective latency L, the first beat shows dvalid_o=1 in the cycle after the L-th rising edge, counting the command edge as the first. Latency codes 1 to 3 are used as given, code 0 acts as 1, and codes 4 to 7 act as 3.
- R4: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. busy_o is high from the command edge through the cycle that shows the last beat, then low. dvalid_o is never high while busy_o is low.
- R5: In linear order, beat i uses column base + ((s mod BL) + i) mod BL. Here s is the start column from addr_i[7:0] and base is s rounded down to a multiple of BL.
- R6: In interleaved order, beat i uses column base + ((s mod BL) xor i). The order bit is ignored for full-page bursts, which are always linear.
- R7: Length code 7 selects a full-page burst. Beat i uses column (s + i) mod 256, and the burst continues without end until a stop or a new read or write.
- R8: A burst stop prevents any beat from being generated at or after its edge. Beats generated before that edge still appear after the latency.
- R9: A read or write issued during a burst drops the remaining old beats. The new burst's beats follow straight after the old beats already generated.
- R10: At an edge with cke_i=0, the mode, the burst position and all outputs hold, and any command is ignored.
- R11: During a burst, one beat is produced per enabled clock, with no gaps.
- R12: The unused length codes 4, 5 and 6 give a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low freezes all state |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| addr_i | input | ADDR_W (12) | Mode value or start column |
| col_o | output | COL_W (8) | Column of the current beat |
| dvalid_o | output | 1 | A beat is present this cycle |
| busy_o | output | 1 | A burst has beats outstanding |

## Verification
Some properties are checked on every cycle by the assertions. A mode load captures the address bits. A non-full-page burst never leaves its aligned block or runs past its length. An active burst emits a beat on every enabled edge. dvalid_o implies busy_o. A low clock enable leaves every output unchanged. Other behaviour can only be shown by the bench's scenarios, which sweep every latency, length, order and several start columns: the exact latency, the column orders, the wrap of a full page, the effect of stop and of replacing a burst, and commands ignored under a high chip select.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int MODE_W  = 7;
  localparam int LAT_MAX = 3;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MODE, CMD_READ, CMD_WRITE, CMD_STOP
  } cmd_e;

  typedef struct packed {
    logic [2:0] lat;
    logic       ilv;
    logic [2:0] bl;
  } mode_t;

  localparam mode_t MODE_RST = '{lat: 3'd1, ilv: 1'b0, bl: 3'd0};

  function automatic cmd_e decode_cmd(logic cs_n, logic ras_n, logic cas_n, logic we_n);
    if (cs_n) return CMD_NOP;
    case ({ras_n, cas_n, we_n})
      3'b000:  return CMD_MODE;
      3'b101:  return CMD_READ;
      3'b100:  return CMD_WRITE;
      3'b110:  return CMD_STOP;
      default: return CMD_NOP;
    endcase
  endfunction
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       load_i,
  input  logic [MODE_W-1:0]          data_i,
  output logic [1:0]                 lat_o,
  output logic                       ilv_o,
  output logic                       full_o,
  output logic [COL_W-1:0]           mask_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            mode_q <= MODE_RST;
    else if (en_i && load_i) mode_q <= mode_t'(data_i);
  end

  always_comb begin
    if (mode_q.lat == 3'd0)      lat_o = 2'd1;
    else if (mode_q.lat > 3'd3)  lat_o = 2'd3;
    else                         lat_o = mode_q.lat[1:0];
  end

  assign ilv_o  = mode_q.ilv;
  assign full_o = (mode_q.bl == 3'd7);

  always_comb begin
    case (mode_q.bl)
      3'd1:    mask_o = COL_W'(1);
      3'd2:    mask_o = COL_W'(3);
      3'd3:    mask_o = COL_W'(7);
      3'd7:    mask_o = '1;
      default: mask_o = '0;
    endcase
  end

  assert_mode_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && load_i |=> mode_q == $past(data_i));
endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  input  logic             full_i,
  output logic             vld_o,
  output logic [COL_W-1:0] col_o,
  output logic             act_o
);
  logic [COL_W-1:0] start_q, cnt_q, mask_q;
  logic             ilv_q, full_q;

  function automatic logic [COL_W-1:0] beat_col(logic [COL_W-1:0] s, logic [COL_W-1:0] n,
                                                logic [COL_W-1:0] m, logic x);
    logic [COL_W-1:0] off;
    off = x ? (s ^ n) : (s + n);
    return (s & ~m) | (off & m);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0; vld_o <= 1'b0; col_o <= '0;
      start_q <= '0; cnt_q <= '0; mask_q <= '0; ilv_q <= 1'b0; full_q <= 1'b0;
    end else if (en_i) begin
      if (start_i) begin
        start_q <= col_i;
        cnt_q   <= COL_W'(1);
        mask_q  <= mask_i;
        ilv_q   <= ilv_i & ~full_i;  // full page is always linear
        full_q  <= full_i;
        col_o   <= col_i;
        vld_o   <= 1'b1;
        act_o   <= full_i | (mask_i != '0);
      end else if (stop_i) begin
        act_o <= 1'b0;
        vld_o <= 1'b0;
      end else if (act_o) begin
        col_o <= beat_col(start_q, cnt_q, mask_q, ilv_q);
        vld_o <= 1'b1;
        cnt_q <= cnt_q + COL_W'(1);
        if (!full_q && cnt_q == mask_q) act_o <= 1'b0;
      end else begin
        vld_o <= 1'b0;
      end
    end
  end

  assert_beat_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o && !full_q |-> cnt_q <= mask_q);
  assert_in_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !full_q |-> (col_o & ~mask_q) == (start_q & ~mask_q));
  assert_next_beat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && act_o && !stop_i |=> vld_o);
endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe
  import sdram_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       lat_i,
  input  logic             act_i,
  input  logic             vld_i,
  input  logic [COL_W-1:0] col_i,
  output logic             vld_o,
  output logic [COL_W-1:0] col_o,
  output logic             busy_o
);
  logic [LAT_MAX-1:1]            vld_q;
  logic [LAT_MAX-1:1][COL_W-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      col_q <= '0;
    end else if (en_i) begin
      vld_q[1] <= vld_i;
      col_q[1] <= col_i;
      for (int i = 2; i < LAT_MAX; i++) begin
        vld_q[i] <= vld_q[i-1];
        col_q[i] <= col_q[i-1];
      end
    end
  end

  always_comb begin
    vld_o  = vld_i;
    col_o  = col_i;
    busy_o = act_i | vld_i;
    for (int i = 1; i < LAT_MAX; i++) begin
      if (int'(lat_i) == i + 1) begin
        vld_o = vld_q[i];
        col_o = col_q[i];
      end
      if (i < int'(lat_i)) busy_o = busy_o | vld_q[i];
    end
  end

  assert_valid_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> busy_o);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [COL_W-1:0]  col_o,
  output logic              dvalid_o,
  output logic              busy_o
);
  cmd_e             cmd;
  logic [1:0]       lat;
  logic             ilv, full, g_vld, g_act;
  logic [COL_W-1:0] mask, g_col;

  assign cmd = decode_cmd(cs_ni, ras_ni, cas_ni, we_ni);

  sdram_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk_i, .rst_ni, .en_i(cke_i), .load_i(cmd == CMD_MODE),
    .data_i(addr_i[MODE_W-1:0]), .lat_o(lat), .ilv_o(ilv), .full_o(full), .mask_o(mask)
  );

  sdram_burst_gen #(.COL_W(COL_W)) u_gen (
    .clk_i, .rst_ni, .en_i(cke_i),
    .start_i(cmd == CMD_READ || cmd == CMD_WRITE), .stop_i(cmd == CMD_STOP),
    .col_i(addr_i[COL_W-1:0]), .mask_i(mask), .ilv_i(ilv), .full_i(full),
    .vld_o(g_vld), .col_o(g_col), .act_o(g_act)
  );

  sdram_lat_pipe #(.COL_W(COL_W)) u_pipe (
    .clk_i, .rst_ni, .en_i(cke_i), .lat_i(lat), .act_i(g_act),
    .vld_i(g_vld), .col_i(g_col), .vld_o(dvalid_o), .col_o(col_o), .busy_o(busy_o)
  );

  assert_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(col_o) && $stable(dvalid_o) && $stable(busy_o));
endmodule

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int COL_W  = 8;

  logic clk = 1'b0, rst_ni = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [COL_W-1:0]  col;
  logic dvalid, busy;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_sdram_burst_seq (
    .clk_i(clk), .rst_ni, .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .addr_i(addr), .col_o(col), .dvalid_o(dvalid), .busy_o(busy)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic drive(logic c, logic r, logic ca, logic w, int a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; addr = ADDR_W'(a);
  endtask

  task automatic nop();            drive(1'b0, 1'b1, 1'b1, 1'b1, 0); endtask
  task automatic rd(int a);        drive(1'b0, 1'b1, 1'b0, 1'b1, a); endtask
  task automatic wr(int a);        drive(1'b0, 1'b1, 1'b0, 1'b0, a); endtask
  task automatic stp();            drive(1'b0, 1'b1, 1'b1, 1'b0, 0); endtask

  task automatic mode_load(int cl_code, int ilv, int bl_code);
    drive(1'b0, 1'b0, 1'b0, 1'b0, (cl_code << 4) | (ilv << 3) | bl_code);
    cyc();
    nop();
  endtask

  function automatic int exp_col(int s, int i, int bl, int ilv);
    int base, off;
    base = s - (s % bl);
    off  = s % bl;
    return ilv ? base + (off ^ i) : base + ((off + i) % bl);
  endfunction

  // burst issued now, followed by NOPs; checks every cycle until drained
  task automatic do_burst(int cl, int ilv, int bl, int s, bit is_wr, string tag);
    if (is_wr) wr(s); else rd(s);
    cyc();
    nop();
    for (int k = 1; k <= cl + bl + 1; k++) begin
      bit v;
      v = (k >= cl) && (k < cl + bl);
      check("R3", int'(dvalid), int'(v));
      check("R4", int'(busy), int'(k <= cl + bl - 1));
      if (v) check(tag, int'(col), exp_col(s, k - cl, bl, ilv));
      cyc();
    end
  endtask

  task automatic run_burst(int cl_code, int cl, int ilv, int bl_code, int bl, int s,
                           bit is_wr, string tag);
    mode_load(cl_code, ilv, bl_code);
    do_burst(cl, ilv, bl, s, is_wr, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int starts[4];
    starts = '{0, 5, 'h37, 'hFE};
    cyc(); cyc();
    rst_ni = 1'b1;
    nop();
    cyc();
    // reset state
    check("R2", int'(dvalid), 0);
    check("R2", int'(busy), 0);
    check("R2", int'(col), 0);
    // reset mode: latency 1, one beat
    do_burst(1, 0, 1, 9, 1'b0, "R2");

    // sweep latency, length, order and start column (R3 R4 R5 R6 R11)
    for (int cl = 1; cl <= 3; cl++)
      for (int bc = 0; bc <= 3; bc++)
        for (int il = 0; il <= 1; il++)
          for (int si = 0; si < 4; si++)
            run_burst(cl, cl, il, bc, 1 << bc, starts[si], 1'(si & 1), il ? "R6" : "R5");

    // latency code mapping R3, reserved length codes R12
    run_burst(0, 1, 0, 2, 4, 'h21, 1'b0, "R3");
    run_burst(6, 3, 1, 1, 2, 'h43, 1'b1, "R3");
    run_burst(2, 2, 0, 5, 1, 'h33, 1'b0, "R12");
    run_burst(3, 3, 1, 6, 1, 'h34, 1'b1, "R12");

    // R1: ignored commands under cs_ni high or unused encodings
    mode_load(2, 0, 3);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 'h19);  // load with chip deselected
    cyc();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 'h50);  // read with chip deselected
    cyc();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 'h50);  // unused encoding
    cyc();
    nop();
    for (int k = 0; k < 4; k++) begin
      check("R1", int'(dvalid), 0);
      check("R1", int'(busy), 0);
      cyc();
    end
    do_burst(2, 0, 8, 3, 1'b0, "R1");

    // R9: new read during a burst, latency 2, length 8
    rd(0);
    cyc();
    nop();
    for (int k = 1; k <= 13; k++) begin
      bit v;
      int e;
      v = (k >= 2) && (k <= 12);
      e = (k <= 4) ? k - 2 : 'h10 + (k - 5);
      check("R9", int'(dvalid), int'(v));
      if (v) check("R9", int'(col), e);
      if (k == 13) check("R9", int'(busy), 0);
      if (k == 3) rd('h10);
      else nop();
      cyc();
    end

    // R10: clock enable low freezes state and ignores commands
    mode_load(1, 0, 3);
    rd(0);
    cyc();
    nop();
    for (int k = 1; k <= 12; k++) begin
      int beat;
      beat = (k <= 2) ? k - 1 : (k <= 5) ? 1 : k - 4;
      check("R10", int'(dvalid), int'(k <= 11));
      if (k <= 11) check("R10", int'(col), beat);
      check("R10", int'(busy), int'(k <= 11));
      if (k == 2) begin cke = 1'b0; rd('h40); end
      if (k == 5) begin cke = 1'b1; nop(); end
      cyc();
    end

    // R7: full page linear wraps at 256, ended by stop (R8)
    mode_load(1, 0, 7);
    rd('hFC);
    cyc();
    nop();
    for (int k = 1; k <= 261; k++) begin
      check("R7", int'(dvalid), 1);
      check("R7", int'(col), ('hFC + k - 1) % 256);
      if (k == 261) stp();
      cyc();
    end
    nop();
    check("R8", int'(dvalid), 0);
    check("R8", int'(busy), 0);
    cyc();
    check("R8", int'(dvalid), 0);

    // R6: full page ignores interleave; R8 stop with latency 2
    mode_load(2, 1, 7);
    wr('h7E);
    cyc();
    nop();
    for (int k = 1; k <= 8; k++) begin
      bit v;
      v = (k >= 2) && (k <= 7);
      check("R8", int'(dvalid), int'(v));
      if (v) check("R6", int'(col), 'h7E + k - 2);
      if (k == 8) check("R8", int'(busy), 0);
      if (k == 6) stp();
      else nop();
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule